// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Output Port

This block takes stereo sample pairs from a converter core and sends them out, most significant bit first, on one serial data line. In master role it builds the bit clock, the frame (left/right) clock and a frame-sync strobe from a clock enable that pulses at 256 times the sample rate. The strobe is high exactly while valid data bits are on the line. In slave role those three timing signals come in from an external controller. They are resynchronised into the block clock, and the external frame-sync input gates the shifting.

Sample pairs enter through a valid/ready stream holding one pair. A pair is accepted in a cycle where both `smp_valid` and `smp_ready` are high. A source that sees `smp_ready` low must keep `smp_valid` and its data steady until a transfer happens. The pair in the holding register is taken over at the start of the next frame, and that frees the holding register. If no new pair has arrived by then, the previous pair is sent again. The role and format pins are static and are changed only while reset is asserted.

The 256x enable is expected to be already divided down from whatever system clock ratio the role code names. All three master codes therefore give the same serial timing. In slave role, each half period of the external bit clock must last longer than the synchroniser depth plus two block clock cycles.

Top module: `asp_serial_port`

## Requirements
- R1: While reset is held and in the first cycles after it, `dout` is 0, `smp_ready` is 1, and `clk_drive_en` is 1 exactly when `role` is not 00.
- R2: `role` 00 selects slave: `clk_drive_en`, `bck_out`, `lrck_out` and `fsync_out` stay 0. The codes 01, 10 and 11 select master, with identical serial timing for all three.
- R3: In master role, each bit clock period lasts TICKS_PER_BIT (4) enable pulses, with the low half first. Each frame clock period holds 64 bit clocks, 32 with the frame clock high and 32 with it low. The frame clock and frame sync change only together with a falling edge of the bit clock.
- R4: `fmt` 00 selects 24-bit left-justified, 01 selects 24-bit I2S, 10 selects 24-bit right-justified and 11 selects 20-bit right-justified. The left channel uses the frame-clock-high half for 00, 10 and 11 and the frame-clock-low half for 01. Every master frame begins with the left half.
- R5: In master role, bit positions in a 32-bit half are counted 0 to 31 from the frame clock edge. The frame sync is high on positions 0..W-1 for left-justified, 1..W for I2S, and 32-W..31 for right-justified, where W is 24, or 20 for `fmt` 11. Elsewhere it is low.
- R6: Data goes out MSB first as two's complement. In 20-bit mode, sample bits 23 down to 4 are sent. The line is 0 on every bit position outside the data window.
- R7: In slave role, `dout` is 0 while `fsync_in` is low. The first bit with `fsync_in` high carries the MSB of the channel selected by `lrck_in`, and each later bit clock with `fsync_in` high carries the next bit. This holds for 64 and for 48 bit clocks per frame, and for a frame-sync lag of up to 16 or 12 bit clocks respectively.
- R8: Both channels of a frame come from the same pair. That pair is latched when the left half begins. If no new pair was accepted since the previous frame start, the previous pair is repeated.
- R9: `smp_ready` is high exactly when the holding register is empty. After a transfer it stays low until the next left-half start, and it does not accept data while low.
- R10: `dout` changes only after a falling bit clock edge. In master role it is steady for as long as `bck_out` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_256 | input | 1 | Clock enable pulsing at 256 times the sample rate |
| role | input | 2 | 00 slave, 01/10/11 master |
| fmt | input | 2 | Serial format select (see R4) |
| smp_valid | input | 1 | Sample pair valid |
| smp_ready | output | 1 | Holding register empty |
| smp_left | input | SAMPLE_W | Left sample, two's complement |
| smp_right | input | SAMPLE_W | Right sample, two's complement |
| bck_in | input | 1 | External bit clock (slave) |
| lrck_in | input | 1 | External frame clock (slave) |
| fsync_in | input | 1 | External frame sync / shift enable (slave) |
| bck_out | output | 1 | Generated bit clock (master) |
| lrck_out | output | 1 | Generated frame clock (master) |
| fsync_out | output | 1 | Generated frame sync (master) |
| clk_drive_en | output | 1 | Pad drive enable for the three timing pins |
| dout | output | 1 | Serial data |

## Verification
Master runs go through all four format codes, and the three master role codes are spread over them. Each frame's data line, frame clock and frame sync are compared bit by bit against a model built from the window rules, so a wrong channel polarity, an I2S off-by-one or a right-justified misplacement shows up as a wrong bit position. Random sample values make a swapped channel or a truncation visible, and one run withholds a pair so that a repeated frame can be told apart from a freshly latched one. Slave runs use 64- and 48-clock frames with random frame-sync lags, which separates shifting gated by the external strobe from shifting timed by the frame clock alone.

// File: rtl/asp_pkg.sv
package asp_pkg;

  typedef enum logic [1:0] {
    FMT_LJ24 = 2'b00,
    FMT_I2S24 = 2'b01,
    FMT_RJ24 = 2'b10,
    FMT_RJ20 = 2'b11
  } asp_fmt_e;

  // Word length carried by a format
  function automatic int word_len(input asp_fmt_e f, input int long_w, input int short_w);
    return (f == FMT_RJ20) ? short_w : long_w;
  endfunction

  // Frame clock level that marks the left half
  function automatic logic left_level(input asp_fmt_e f);
    return (f != FMT_I2S24);
  endfunction

  // True when slot position pos carries a data bit
  function automatic logic in_window(input asp_fmt_e f, input int pos, input int slot, input int wlen);
    case (f)
      FMT_LJ24:  return (pos < wlen);
      FMT_I2S24: return (pos >= 1) && (pos <= wlen);
      default:   return (pos >= slot - wlen);
    endcase
  endfunction

endpackage

// File: rtl/asp_pin_sync.sv
module asp_pin_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/asp_master_clkgen.sv
module asp_master_clkgen
  import asp_pkg::*;
#(
  parameter int TICKS_PER_BIT = 4,
  parameter int SLOT_BITS     = 32,
  parameter int LONG_W        = 24,
  parameter int SHORT_W       = 20
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  logic     tick,
  input  asp_fmt_e fmt,
  output logic     bck_o,
  output logic     lrck_o,
  output logic     fsync_o
);
  localparam int FRAME_BITS = 2 * SLOT_BITS;
  localparam int PH_W = $clog2(TICKS_PER_BIT);
  localparam int BI_W = $clog2(FRAME_BITS);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(TICKS_PER_BIT - 1);
  localparam logic [PH_W-1:0] PH_HIGH = PH_W'(TICKS_PER_BIT / 2);
  localparam logic [BI_W-1:0] BI_LAST = BI_W'(FRAME_BITS - 1);
  localparam logic [BI_W-1:0] SLOT_B  = BI_W'(SLOT_BITS);

  logic [PH_W-1:0] phase;
  logic [BI_W-1:0] bidx;
  logic            right_half;
  logic [BI_W-1:0] pos;
  int              wlen;

  // Counters rest on the last phase of the last bit so the first tick opens a frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_LAST;
      bidx  <= BI_LAST;
    end else if (!run) begin
      phase <= PH_LAST;
      bidx  <= BI_LAST;
    end else if (tick) begin
      if (phase == PH_LAST) begin
        phase <= '0;
        bidx  <= (bidx == BI_LAST) ? '0 : bidx + 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  assign right_half = (bidx >= SLOT_B);
  assign pos        = right_half ? (bidx - SLOT_B) : bidx;
  assign wlen       = word_len(fmt, LONG_W, SHORT_W);

  assign bck_o   = (phase >= PH_HIGH);
  assign lrck_o  = right_half ? ~left_level(fmt) : left_level(fmt);
  assign fsync_o = in_window(fmt, int'(pos), SLOT_BITS, wlen);

  // R3: the frame clock moves only on a falling bit clock
  a_r3_lrck_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !$stable(lrck_o)) |-> $fell(bck_o));

  // R5: the frame sync moves only on a falling bit clock
  a_r5_fsync_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !$stable(fsync_o)) |-> $fell(bck_o));
endmodule

// File: rtl/asp_frame_buffer.sv
module asp_frame_buffer #(
  parameter int SW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  output logic          smp_ready,
  input  logic [SW-1:0] smp_left,
  input  logic [SW-1:0] smp_right,
  input  logic          frame_start,
  output logic [SW-1:0] next_left,
  output logic [SW-1:0] cur_right
);
  logic          full;
  logic [SW-1:0] hold_l, hold_r;
  logic [SW-1:0] frm_l, frm_r;
  logic          accept;

  assign smp_ready = ~full;
  assign accept    = smp_valid & ~full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full   <= 1'b0;
      hold_l <= '0;
      hold_r <= '0;
      frm_l  <= '0;
      frm_r  <= '0;
    end else begin
      if (accept) begin
        hold_l <= smp_left;
        hold_r <= smp_right;
      end
      if (frame_start && full) begin
        frm_l <= hold_l;
        frm_r <= hold_r;
      end
      full <= accept ? 1'b1 : (frame_start ? 1'b0 : full);
    end
  end

  // Left word to load when a frame opens: fresh pair if present, else repeat
  assign next_left = full ? hold_l : frm_l;
  assign cur_right = frm_r;

  // R9: a transfer fills the holding register
  a_r9_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> !smp_ready);

  // R9: a full holding register stays full until a frame opens
  a_r9_ready_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_ready && !frame_start) |=> !smp_ready);

  // R8: a frame start frees a full holding register
  a_r8_release_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_ready && frame_start) |=> smp_ready);
endmodule

// File: rtl/asp_shift_engine.sv
module asp_shift_engine #(
  parameter int SW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bck,
  input  logic          lrck,
  input  logic          fsync,
  input  logic          left_lvl,
  input  logic [SW-1:0] word_left,
  input  logic [SW-1:0] word_right,
  output logic          frame_start,
  output logic          dout
);
  logic          bck_q, lrck_q, fs_q, fs_cap;
  logic          bck_fall, bck_rise, lrck_chg;
  logic [SW-1:0] shreg;

  assign bck_fall    = bck_q & ~bck;
  assign bck_rise    = ~bck_q & bck;
  assign lrck_chg    = (lrck != lrck_q);
  assign frame_start = lrck_chg & (lrck == left_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_q  <= 1'b0;
      lrck_q <= 1'b0;
      fs_q   <= 1'b0;
      fs_cap <= 1'b0;
      shreg  <= '0;
    end else begin
      bck_q  <= bck;
      lrck_q <= lrck;
      fs_q   <= fsync;
      if (bck_rise) fs_cap <= fsync;
      // A half boundary reloads the word; otherwise advance after an enabled bit
      if (lrck_chg)                shreg <= (lrck == left_lvl) ? word_left : word_right;
      else if (bck_fall && fs_cap) shreg <= {shreg[SW-2:0], 1'b0};
    end
  end

  assign dout = fs_q & shreg[SW-1];
endmodule

// File: rtl/asp_serial_port.sv
module asp_serial_port
  import asp_pkg::*;
#(
  parameter int SAMPLE_W      = 24,
  parameter int SHORT_W       = 20,
  parameter int SLOT_BITS     = 32,
  parameter int TICKS_PER_BIT = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_256,
  input  logic [1:0]          role,
  input  logic [1:0]          fmt,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic                bck_in,
  input  logic                lrck_in,
  input  logic                fsync_in,
  output logic                bck_out,
  output logic                lrck_out,
  output logic                fsync_out,
  output logic                clk_drive_en,
  output logic                dout
);
  localparam int NPINS = 3;

  asp_fmt_e            fmt_e;
  logic                master;
  logic                g_bck, g_lrck, g_fsync;
  logic [NPINS-1:0]    ext_s;
  logic                s_bck, s_lrck, s_fsync;
  logic                frame_start;
  logic [SAMPLE_W-1:0] next_left, cur_right;

  assign fmt_e  = asp_fmt_e'(fmt);
  assign master = (role != 2'b00);

  asp_master_clkgen #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .SLOT_BITS    (SLOT_BITS),
    .LONG_W       (SAMPLE_W),
    .SHORT_W      (SHORT_W)
  ) u_clkgen (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (master),
    .tick   (tick_256),
    .fmt    (fmt_e),
    .bck_o  (g_bck),
    .lrck_o (g_lrck),
    .fsync_o(g_fsync)
  );

  asp_pin_sync #(.N(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({fsync_in, lrck_in, bck_in}),
    .q    (ext_s)
  );

  assign s_bck   = master ? g_bck   : ext_s[0];
  assign s_lrck  = master ? g_lrck  : ext_s[1];
  assign s_fsync = master ? g_fsync : ext_s[2];

  asp_frame_buffer #(.SW(SAMPLE_W)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_valid  (smp_valid),
    .smp_ready  (smp_ready),
    .smp_left   (smp_left),
    .smp_right  (smp_right),
    .frame_start(frame_start),
    .next_left  (next_left),
    .cur_right  (cur_right)
  );

  asp_shift_engine #(.SW(SAMPLE_W)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .bck        (s_bck),
    .lrck       (s_lrck),
    .fsync      (s_fsync),
    .left_lvl   (left_level(fmt_e)),
    .word_left  (next_left),
    .word_right (cur_right),
    .frame_start(frame_start),
    .dout       (dout)
  );

  assign bck_out      = master & g_bck;
  assign lrck_out     = master & g_lrck;
  assign fsync_out    = master & g_fsync;
  assign clk_drive_en = master;

  // R10: the data line holds still through the high half of the bit clock
  a_r10_dout_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (master && bck_out && $past(bck_out)) |-> $stable(dout));

  // R2: slave role never drives the timing pins
  a_r2_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_drive_en) |-> (!bck_out && !lrck_out && !fsync_out));
endmodule

// File: tb/asp_serial_port_tb.sv
module asp_serial_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TPB        = 4;
  localparam int MAXP       = 12;
  localparam int HB         = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_256 = 1'b0;
  logic [1:0]  role = 2'b01;
  logic [1:0]  fmt = 2'b00;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [23:0] smp_left = '0, smp_right = '0;
  logic        bck_in = 1'b1, lrck_in = 1'b0, fsync_in = 1'b0;
  logic        bck_out, lrck_out, fsync_out, clk_drive_en, dout;

  asp_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .tick_256(tick_256), .role(role), .fmt(fmt),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_left(smp_left), .smp_right(smp_right),
    .bck_in(bck_in), .lrck_in(lrck_in), .fsync_in(fsync_in),
    .bck_out(bck_out), .lrck_out(lrck_out), .fsync_out(fsync_out),
    .clk_drive_en(clk_drive_en), .dout(dout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  logic [23:0] pl [MAXP];
  logic [23:0] pr [MAXP];
  int gate [MAXP];
  int n_push, next_push, unit_cnt, cyc;
  bit tick_en = 0, push_en = 0, mon_on = 0, rdy_q = 0;
  int cur_skip;
  logic prev_bck, prev_dout;
  int rise_cnt, last_rise, bad_period, bad_stable;
  logic [63:0] got_d, got_l, got_f;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
    end
  endtask

  function automatic logic lvl_of(input logic [1:0] f);
    return (f != 2'b01);
  endfunction
  function automatic int wl_of(input logic [1:0] f);
    return (f == 2'b11) ? 20 : 24;
  endfunction
  function automatic logic win_of(input logic [1:0] f, input int pos);
    case (f)
      2'b00:   return pos < 24;
      2'b01:   return (pos >= 1) && (pos <= 24);
      default: return pos >= 32 - wl_of(f);
    endcase
  endfunction
  function automatic int idx_of(input logic [1:0] f, input int pos);
    case (f)
      2'b00:   return pos;
      2'b01:   return pos - 1;
      default: return pos - (32 - wl_of(f));
    endcase
  endfunction

  task automatic check_frame(input int f);
    int pi;
    logic [63:0] ed, el, ef;
    logic [23:0] w;
    pi = (cur_skip > 0 && f >= cur_skip) ? f - 1 : f;
    for (int b = 0; b < 64; b++) begin
      int pos;
      pos = b % 32;
      w = (b < 32) ? pl[pi] : pr[pi];
      el[63-b] = (b < 32) ? lvl_of(fmt) : ~lvl_of(fmt);
      ef[63-b] = win_of(fmt, pos);
      ed[63-b] = win_of(fmt, pos) ? w[23 - idx_of(fmt, pos)] : 1'b0;
    end
    chk(got_l === el, "R4", "master lrck pattern", got_l, el);
    chk(got_f === ef, "R5", "master fsync window", got_f, ef);
    chk(got_d === ed, (cur_skip > 0 && f == cur_skip) ? "R8" : "R6",
        "master data bits", got_d, ed);
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    tick_256 = tick_en && !tick_256;
    if (push_en) begin
      if (smp_valid && rdy_q) begin
        smp_valid = 1'b0;
        next_push++;
      end
      if (!smp_valid && next_push < n_push && unit_cnt >= gate[next_push]) begin
        smp_valid = 1'b1;
        smp_left  = pl[next_push];
        smp_right = pr[next_push];
      end
    end
    rdy_q = smp_ready;
    if (mon_on) begin
      if (bck_out && !prev_bck) begin
        int b;
        if (rise_cnt > 0 && cyc - last_rise != 2 * TPB) bad_period++;
        last_rise = cyc;
        b = rise_cnt % 64;
        got_d[63-b] = dout;
        got_l[63-b] = lrck_out;
        got_f[63-b] = fsync_out;
        if (b == 63) check_frame(rise_cnt / 64);
        rise_cnt++;
        unit_cnt = rise_cnt;
      end
      if (bck_out && prev_bck && dout !== prev_dout) bad_stable++;
      prev_bck  = bck_out;
      prev_dout = dout;
    end
  endtask

  task automatic do_reset();
    smp_valid = 1'b0;
    tick_en = 0; push_en = 0; mon_on = 0;
    rst_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (2) step();
  endtask

  task automatic fill_pairs(input int n);
    for (int i = 0; i < n; i++) begin
      pl[i] = 24'($urandom);
      pr[i] = 24'($urandom);
      gate[i] = 0;
    end
    pl[0] = 24'h800001; pr[0] = 24'h7FFFFE;
    n_push = n; next_push = 0; unit_cnt = 0;
  endtask

  task automatic master_run(input logic [1:0] m, input logic [1:0] f, input int nfr, input int skip);
    role = m; fmt = f; cur_skip = skip;
    do_reset();
    chk(dout === 1'b0 && smp_ready === 1'b1, "R1", "reset dout/ready",
        {62'd0, dout, smp_ready}, 64'd1);
    chk(clk_drive_en === 1'b1, "R2", "master drive enable", {63'd0, clk_drive_en}, 64'd1);
    fill_pairs(nfr);
    if (skip > 0) gate[skip] = skip * 64 + 2;
    push_en = 1;
    while (next_push < 1) step();
    repeat (6) step();
    chk(smp_ready === 1'b0 && smp_valid === 1'b1, "R9", "blocked while holding full",
        {63'd0, smp_ready}, 64'd0);
    rise_cnt = 0; bad_period = 0; bad_stable = 0;
    prev_bck = bck_out; prev_dout = dout;
    mon_on = 1; tick_en = 1;
    while (rise_cnt < nfr * 64) step();
    mon_on = 0; tick_en = 0;
    chk(bad_period == 0, "R3", "bit clock period", 64'(bad_period), 64'd0);
    chk(bad_stable == 0, "R10", "data steady while bck high", 64'(bad_stable), 64'd0);
  endtask

  task automatic slave_run(input logic [1:0] f, input int fbits, input int nfr);
    int slot, w, maxlag;
    role = 2'b00; fmt = f; cur_skip = 0;
    slot = fbits / 2; w = wl_of(f);
    maxlag = slot - w;
    if (maxlag > ((fbits == 64) ? 16 : 12)) maxlag = (fbits == 64) ? 16 : 12;
    bck_in = 1'b1; lrck_in = ~lvl_of(f); fsync_in = 1'b0;
    do_reset();
    chk(clk_drive_en === 1'b0 && bck_out === 1'b0 && lrck_out === 1'b0 && fsync_out === 1'b0,
        "R2", "slave pins idle", {60'd0, clk_drive_en, bck_out, lrck_out, fsync_out}, 64'd0);
    chk(dout === 1'b0 && smp_ready === 1'b1, "R1", "slave reset dout/ready",
        {62'd0, dout, smp_ready}, 64'd1);
    fill_pairs(nfr);
    push_en = 1;
    while (next_push < 1) step();
    for (int fr = 0; fr < nfr; fr++) begin
      for (int s = 0; s < 2; s++) begin
        int lag;
        logic [23:0] wd;
        logic [63:0] got, exp;
        lag = (maxlag > 0) ? int'($urandom % (maxlag + 1)) : 0;
        wd = s ? pr[fr] : pl[fr];
        got = '0; exp = '0;
        for (int j = 0; j < slot; j++) begin
          logic fs;
          fs = (j >= lag) && (j < lag + w);
          bck_in = 1'b0;
          lrck_in = s ? ~lvl_of(f) : lvl_of(f);
          fsync_in = fs;
          repeat (HB) step();
          got[j] = dout;
          exp[j] = fs ? wd[23 - (j - lag)] : 1'b0;
          bck_in = 1'b1;
          repeat (HB) step();
        end
        unit_cnt++;
        chk(got === exp, "R7", $sformatf("slave slot fbits=%0d lag=%0d", fbits, lag), got, exp);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20250611));
    cyc = 0;
    master_run(2'b01, 2'b00, 3, 0);
    master_run(2'b10, 2'b01, 3, 0);
    master_run(2'b11, 2'b10, 3, 0);
    master_run(2'b01, 2'b11, 4, 2);   // R8 repeated pair in frame 2
    for (int k = 0; k < 2; k++)
      master_run(2'($urandom % 3 + 1), 2'($urandom), 2, 0);
    slave_run(2'b00, 64, 2);
    slave_run(2'b11, 48, 2);
    slave_run(2'b01, 64, 2);
    slave_run(2'b10, 48, 1);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule